// File: doc/BRIEF.md
# DMA channel priority arbiter

This block decides, every clock cycle, which one of four DMA channels may use the bus. Each channel raises a request line. The arbiter returns a registered, one-hot grant that names at most one requesting channel. A 16-bit control and status register, which the CPU reads and writes through a simple strobe port, selects the arbitration policy. There are three fixed orders, each with its own channel ranking, and a rotating round-robin order.

The same register holds a sticky address-error flag. An address-error pulse from the transfer logic sets the flag, and while it is set no channel is granted. Software cannot set the flag itself. To clear it, software must first read the register while the flag shows 1 and then write 0 to the flag bit. A hidden arming bit records that read. Any register write consumes the arming bit.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset the register reads 0x0000, the grant is all zero, and the round-robin pointer is set so that channel 0 is highest.
- R2: The mode field sits at bits 9:8 and reads back what was last written. The flag sits at bit 2. All other bits (15:10, 7:3, 1:0) always read 0, and writing 1s to them has no effect.
- R3: Mode 00 ranks the channels 0, 1, 2, 3, highest first.
- R4: Mode 01 ranks the channels 0, 2, 3, 1, highest first.
- R5: Mode 10 ranks the channels 2, 0, 1, 3, highest first.
- R6: Mode 11 is round-robin. The search starts one channel above the most recently granted channel and wraps from 3 to 0. Every issued grant, in any mode, moves the pointer.
- R7: A grant appears one cycle after the requests and mode it was decided on. It is one-hot and names a requesting channel, or it is all zero when nothing requests.
- R8: An address-error pulse sets the flag. The flag reads as 1 from the next cycle. While the flag is 1, the grant decided in that cycle is all zero.
- R9: A CPU write of 1 to bit 2 leaves the flag unchanged, whether it is 0 or 1.
- R10: The flag clears only on a write with bit 2 = 0 that follows a read made while the flag was 1, with no write in between. A write of 0 without such a read leaves the flag set.
- R11: An address-error pulse in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | CPU read strobe for the register |
| wr_en | input | 1 | CPU write strobe for the register |
| wr_data | input | 16 | CPU write data |
| rd_data | output | 16 | Current register contents |
| addr_err | input | 1 | Address-error event pulse |
| req | input | 4 | Channel request lines |
| grant | output | 4 | Registered one-hot channel grant |

## Verification
The bench builds the block with its default parameters: a 16-bit register, the mode field at bits 9:8 and the flag at bit 2. Each setting of the mode field is therefore reachable by a plain data write, including mode 11 with every pointer position. Random writes also put 1s into every reserved position, so reserved-bit leakage can be observed. Random request patterns, mixed with occasional error pulses and reads, reach the arm, cancel and clear orderings. Directed sequences pin the rotation after reset and the simultaneous error-and-clear case.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_ALT_A  = 2'b01,
    MODE_ALT_B  = 2'b10,
    MODE_ROTATE = 2'b11
  } prio_mode_e;

  // Channel that holds a given rank (0 = highest) in a fixed mode.
  function automatic logic [CW-1:0] rank_to_chan(logic [1:0] m, int unsigned rank);
    logic [2*NCH-1:0] tbl;
    case (m)
      MODE_ALT_A: tbl = {2'd1, 2'd3, 2'd2, 2'd0};
      MODE_ALT_B: tbl = {2'd3, 2'd1, 2'd0, 2'd2};
      default:    tbl = {2'd3, 2'd2, 2'd1, 2'd0};
    endcase
    return tbl[rank*CW +: CW];
  endfunction

  function automatic logic [NCH-1:0] onehot_of(logic [CW-1:0] c);
    logic [NCH-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [CW-1:0] index_of(logic [NCH-1:0] oh);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (oh[i]) idx = CW'(i);
    end
    return idx;
  endfunction

  // Next channel after `base`, wrapping at NCH.
  function automatic logic [CW-1:0] wrap_next(logic [CW-1:0] base, int unsigned step);
    return CW'((int'(base) + int'(step)) % NCH);
  endfunction
endpackage

// File: rtl/dmaarb_ctrl_reg.sv
module dmaarb_ctrl_reg #(
  parameter int REG_W    = 16,
  parameter int MODE_LSB = 8,
  parameter int ERR_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             addr_err,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       mode,
  output logic             err_flag
);
  logic [1:0] mode_q;
  logic       err_q;
  logic       arm_q;

  // Named events for the assertions
  logic err_set_ev, clr_try_ev, err_clr_ev, arm_set_ev;
  logic unused_wr_bits;

  assign err_set_ev     = addr_err;
  assign clr_try_ev     = wr_en && arm_q && !wr_data[ERR_BIT];
  assign err_clr_ev     = clr_try_ev && !err_set_ev;
  assign arm_set_ev     = rd_en && err_q && !wr_en;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      err_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_en) mode_q <= wr_data[MODE_LSB +: 2];
      if (err_set_ev)      err_q <= 1'b1;
      else if (err_clr_ev) err_q <= 1'b0;
      if (wr_en || err_clr_ev) arm_q <= 1'b0;
      else if (arm_set_ev)     arm_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[MODE_LSB +: 2] = mode_q;
    rd_data[ERR_BIT]       = err_q;
  end

  assign mode     = mode_q;
  assign err_flag = err_q;

  assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> err_q);
  assert_no_cpu_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && !addr_err) |=> !err_q);
  assert_hold_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !arm_q) |=> err_q);
  assert_arm_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> err_q);
  assert_err_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_try_ev && addr_err) |=> err_q);
endmodule

// File: rtl/dmaarb_fixed_pick.sv
module dmaarb_fixed_pick
  import dmaarb_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [1:0]     mode,
  output logic [NCH-1:0] pick_oh
);
  logic [NCH-1:0] cand;

  // Request of the channel holding each rank
  for (genvar r = 0; r < NCH; r++) begin : g_rank
    assign cand[r] = req[rank_to_chan(mode, r)];
  end

  always_comb begin
    pick_oh = '0;
    for (int r = NCH - 1; r >= 0; r--) begin
      if (cand[r]) pick_oh = onehot_of(rank_to_chan(mode, r));
    end
  end
endmodule

// File: rtl/dmaarb_rr_pick.sv
module dmaarb_rr_pick
  import dmaarb_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [CW-1:0]  last,
  output logic [NCH-1:0] pick_oh
);
  logic          found;
  logic [CW-1:0] c;

  always_comb begin
    pick_oh = '0;
    found   = 1'b0;
    c       = '0;
    for (int k = 1; k <= NCH; k++) begin
      c = wrap_next(last, k);
      if (!found && req[c]) begin
        pick_oh = onehot_of(c);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dmaarb_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int MODE_LSB = 8,
  parameter int ERR_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             addr_err,
  input  logic [NCH-1:0]   req,
  output logic [NCH-1:0]   grant
);
  logic [1:0]     mode;
  logic           err_flag;
  logic [NCH-1:0] fix_oh, rr_oh, pick_oh, grant_q;
  logic [CW-1:0]  last_q;
  logic           grant_blocked, grant_issue_ev;

  dmaarb_ctrl_reg #(.REG_W(REG_W), .MODE_LSB(MODE_LSB), .ERR_BIT(ERR_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .addr_err(addr_err), .rd_data(rd_data), .mode(mode), .err_flag(err_flag)
  );

  dmaarb_fixed_pick u_fix (.req(req), .mode(mode), .pick_oh(fix_oh));
  dmaarb_rr_pick    u_rr  (.req(req), .last(last_q), .pick_oh(rr_oh));

  assign pick_oh        = (mode == MODE_ROTATE) ? rr_oh : fix_oh;
  assign grant_blocked  = err_flag;
  assign grant_issue_ev = !grant_blocked && (|pick_oh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= CW'(NCH - 1);
    end else begin
      grant_q <= grant_blocked ? '0 : pick_oh;
      if (grant_issue_ev) last_q <= index_of(pick_oh);
    end
  end

  assign grant = grant_q;

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & ~$past(req)) == '0));
  assert_idle_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0));
  assert_grant_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (grant == '0));
  assert_rr_skips_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ROTATE && !err_flag && (req & ~onehot_of(last_q)) != '0)
      |=> (grant & $past(onehot_of(last_q))) == '0);
endmodule

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0, addr_err = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  req = '0;
  logic [3:0]  grant;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_mode;
  logic       m_ae, m_arm;
  int         m_last;
  logic [3:0] m_grant;
  string      g_tag;

  always #5 clk = ~clk;

  dma_prio_arb dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .addr_err(addr_err), .req(req), .grant(grant));

  function automatic int order_at(logic [1:0] m, int rank);
    int tab[3][4] = '{'{0, 1, 2, 3}, '{0, 2, 3, 1}, '{2, 0, 1, 3}};
    return tab[m][rank];
  endfunction

  function automatic int bench_pick(logic [3:0] q, logic [1:0] m, int last);
    int c;
    if (q == 0) return -1;
    if (m == 2'b11) begin
      c = last;
      repeat (4) begin
        c = (c == 3) ? 0 : c + 1;
        if (q[c]) return c;
      end
      return -1;
    end
    for (int r = 0; r < 4; r++) if (q[order_at(m, r)]) return order_at(m, r);
    return -1;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_ae = 0; m_arm = 0; m_last = 3; m_grant = 0;
  endtask

  // Drive one cycle (called at a negedge), update model at the edge, check at the next negedge.
  task automatic cyc(string rtag, logic r, logic w, logic [15:0] d, logic e, logic [3:0] q);
    int p;
    logic n_ae, n_arm;
    rd_en = r; wr_en = w; wr_data = d; addr_err = e; req = q;
    @(posedge clk);
    #1;
    p = bench_pick(q, m_mode, m_last);
    if (m_ae)        g_tag = "R8";
    else if (q == 0) g_tag = "R7";
    else case (m_mode)
      2'b00: g_tag = "R3";
      2'b01: g_tag = "R4";
      2'b10: g_tag = "R5";
      default: g_tag = "R6";
    endcase
    m_grant = (m_ae || p < 0) ? 4'b0 : 4'(1 << p);
    if (!m_ae && p >= 0) m_last = p;
    n_ae  = e ? 1'b1 : ((w && m_arm && !d[2]) ? 1'b0 : m_ae);
    n_arm = w ? 1'b0 : ((r && m_ae) ? 1'b1 : m_arm);
    if (!n_ae) n_arm = 1'b0;
    if (w) m_mode = d[9:8];
    m_ae = n_ae; m_arm = n_arm;
    @(negedge clk);
    check(g_tag, {12'b0, grant}, {12'b0, m_grant});
    check(rtag, rd_data, {6'b0, m_mode, 5'b0, m_ae, 2'b0});
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 16'h0, 0, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", rd_data, 16'h0000);
    check("R1", {12'b0, grant}, 16'h0000);

    // R6: rotation straight after reset, channel 0 first
    cyc("R2", 0, 1, 16'h0300, 0, 4'h0);
    cyc("R6", 0, 0, 16'h0, 0, 4'hF); check("R6", {12'b0, grant}, 16'h0001);
    cyc("R6", 0, 0, 16'h0, 0, 4'hF); check("R6", {12'b0, grant}, 16'h0002);
    cyc("R6", 0, 0, 16'h0, 0, 4'hF); check("R6", {12'b0, grant}, 16'h0004);
    cyc("R6", 0, 0, 16'h0, 0, 4'hF); check("R6", {12'b0, grant}, 16'h0008);
    cyc("R6", 0, 0, 16'h0, 0, 4'hA); check("R6", {12'b0, grant}, 16'h0002);

    // R2 / R9: all-ones write keeps reserved bits and flag at 0
    cyc("R2", 0, 1, 16'hFFFF, 0, 4'h0);
    check("R9", rd_data, 16'h0300);

    // Fixed orders with all channels requesting and with subsets
    cyc("R2", 0, 1, 16'h0000, 0, 4'h0);
    cyc("R3", 0, 0, 16'h0, 0, 4'hC); check("R3", {12'b0, grant}, 16'h0004);
    cyc("R2", 0, 1, 16'h0100, 0, 4'h0);
    cyc("R4", 0, 0, 16'h0, 0, 4'hA); check("R4", {12'b0, grant}, 16'h0008);
    cyc("R2", 0, 1, 16'h0200, 0, 4'h0);
    cyc("R5", 0, 0, 16'h0, 0, 4'hF); check("R5", {12'b0, grant}, 16'h0004);
    cyc("R5", 0, 0, 16'h0, 0, 4'hB); check("R5", {12'b0, grant}, 16'h0001);

    // R8: error pulse blocks grants
    cyc("R8", 0, 0, 16'h0, 1, 4'h0);
    check("R8", rd_data, 16'h0204);
    cyc("R8", 0, 0, 16'h0, 0, 4'hF); check("R8", {12'b0, grant}, 16'h0000);
    // R10: write 0 without read leaves it set
    cyc("R10", 0, 1, 16'h0200, 0, 4'h0); check("R10", rd_data, 16'h0204);
    // R10: read, then write 1 consumes the arm, then write 0 does nothing
    cyc("R10", 1, 0, 16'h0, 0, 4'h0);
    cyc("R9", 0, 1, 16'h0204, 0, 4'h0); check("R9", rd_data, 16'h0204);
    cyc("R10", 0, 1, 16'h0200, 0, 4'h0); check("R10", rd_data, 16'h0204);
    // R11: armed clear together with error pulse
    cyc("R11", 1, 0, 16'h0, 0, 4'h0);
    cyc("R11", 0, 1, 16'h0200, 1, 4'h0); check("R11", rd_data, 16'h0204);
    // R10: proper read then write 0 clears
    cyc("R10", 1, 0, 16'h0, 0, 4'h0);
    cyc("R10", 0, 1, 16'h0200, 0, 4'h0); check("R10", rd_data, 16'h0200);
    cyc("R7", 0, 0, 16'h0, 0, 4'h6); check("R7", {12'b0, grant}, 16'h0004);
    idle("R7");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic r, w, e;
      logic [15:0] d;
      r = ($urandom % 4) == 0;
      w = ($urandom % 10) == 0;
      e = ($urandom % 50) == 0;
      d = 16'($urandom);
      if (($urandom % 2) == 0) d[2] = 1'b0;
      cyc("R2", r, w, d, e, 4'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule